// File: doc/BRIEF.md
# Shift-Tolerant Logic-Block Input Selector

This block is the input side of a connection block between a routing channel and a logic-block input pin. Without repair, the pin could reach only half of the tracks in the channel: the even-numbered ones in this design. When a routing defect is repaired by moving the signals on a track and every track above it up by one or two places, a signal that the router put on track `t` may instead arrive on `t+1` or `t+2`. To handle that, each even track the pin connects to is widened into a three-tap group `{t, t+1, t+2}`. The selector picks the tap that holds the intended signal.

Each request carries several values:
- a snapshot of the channel's track values;
- the base track the router assigned to the pin;
- the index of the defective track in the trackgroup;
- the repair shift in effect (0, 1 or 2).

If the base track is at or above the defect index, the shifted track `base + shift` is read. If the base track lies below the defect, the signal was never moved and the base track is read as it is. If a request asks for a track the widened pin cannot reach, the selector raises an error flag and delivers zero.

A control module turns the request into a small set of strobes: load, error, tap slot and tap offset. A datapath module holds the widened tap groups and the output registers. Results appear one clock after the request.

Top module: `shift_tolerant_cb_input`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `outValid`, `outBit` and `selErr` are all 0.
- R2: `outValid` is 1 in the cycle after a cycle with `reqValid` high, and 0 after a cycle with `reqValid` low.
- R3: For a valid request whose base track is below `defectTrack`, `outBit` equals `trackVal[baseTrack]`, whatever `shiftAmt` is (0, 1 or 2), and `selErr` is 0.
- R4: For a valid request whose base track is at or above `defectTrack`, `outBit` equals `trackVal[baseTrack + shiftAmt]` for shifts 0, 1 and 2, and `selErr` is 0.
- R5: The pin connects only to even base tracks (bit 0 of `baseTrack` is 0). A request with an odd base track gives `selErr` = 1 and `outBit` = 0.
- R6: Shift code 3 is not a legal repair shift. A request that carries it gives `selErr` = 1 and `outBit` = 0, wherever the defect lies.
- R7: If the effective track `baseTrack + shiftAmt` (shift applied) is beyond the last track (15), the result is `selErr` = 1 and `outBit` = 0. For example, base 14 with shift 2 is an error, while base 14 with shift 1 reads track 15.
- R8: In a cycle after `reqValid` was low, `outBit` and `selErr` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A selection request is present this cycle |
| trackVal | input | 16 | Current value of every routing track in the channel |
| baseTrack | input | 4 | Track the router assigned to the pin |
| defectTrack | input | 4 | Defective track index in the trackgroup |
| shiftAmt | input | 2 | Repair shift in effect: 0, 1 or 2 |
| outValid | output | 1 | A result is present this cycle |
| outBit | output | 1 | Delivered signal value |
| selErr | output | 1 | The request fell outside the widened connected set |

## Verification
The hardest case to reach is the boundary between shifted and unshifted reads: a base track that equals the defect index exactly. Here the shift must apply. With the defect one track higher, it must not. The stimulus sweeps every defect index against every even base track and every legal shift, so each base meets the defect just below, at and above itself. The track values are random, so a wrong tap shows up as a wrong bit. Separate passes reach the top-of-channel overflow at base 14, odd bases and the illegal shift code. Idle gaps between requests exercise the hold behaviour.

// File: rtl/cb_input_pkg.sv
package cb_input_pkg;

  parameter int NUM_TRACKS = 16;
  parameter int STRIDE     = 2;
  parameter int MAX_SHIFT  = 2;

  localparam int IDX_W      = $clog2(NUM_TRACKS);
  localparam int STRIDE_LOG = $clog2(STRIDE);
  localparam int NUM_SLOTS  = NUM_TRACKS / STRIDE;
  localparam int SLOT_W     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam int TAPS       = MAX_SHIFT + 1;
  localparam int SHIFT_W    = $clog2(TAPS + 1);
  localparam int EFF_W      = IDX_W + SHIFT_W;

  typedef struct packed {
    logic               load;
    logic               err;
    logic [SHIFT_W-1:0] offset;
    logic [SLOT_W-1:0]  slot;
  } selStrobe_t;

endpackage

// File: rtl/cb_input_ctrl.sv
module cb_input_ctrl
  import cb_input_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [IDX_W-1:0]   baseTrack,
  input  logic [IDX_W-1:0]   defectTrack,
  input  logic [SHIFT_W-1:0] shiftAmt,
  output selStrobe_t         strobe,
  output logic               outValid
);

  logic               applyShift;
  logic               oddBase;
  logic               badShift;
  logic               overTop;
  logic [SHIFT_W-1:0] useShift;
  logic [EFF_W-1:0]   effTrack;

  // Signals at or above the defect were moved up by the repair.
  assign applyShift = (baseTrack >= defectTrack);
  assign useShift   = applyShift ? shiftAmt : '0;
  assign effTrack   = EFF_W'(baseTrack) + EFF_W'(useShift);

  generate
    if (STRIDE_LOG > 0) begin : g_stride
      assign oddBase = (baseTrack[STRIDE_LOG-1:0] != '0);
    end else begin : g_full
      assign oddBase = 1'b0;
    end
  endgenerate

  assign badShift = (shiftAmt > SHIFT_W'(MAX_SHIFT));
  assign overTop  = (effTrack > EFF_W'(NUM_TRACKS - 1));

  always_comb begin
    strobe        = '0;
    strobe.load   = reqValid;
    strobe.err    = oddBase | badShift | overTop;
    strobe.offset = useShift;
    strobe.slot   = SLOT_W'(baseTrack >> STRIDE_LOG);
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= reqValid;
  end

endmodule

// File: rtl/cb_input_datapath.sv
module cb_input_datapath
  import cb_input_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_TRACKS-1:0] trackVal,
  input  selStrobe_t            strobe,
  output logic                  outBit,
  output logic                  selErr
);

  // Widened connectivity: every connected base track owns a group of TAPS
  // wires, the base itself and the tracks a repair may move it onto.
  logic [TAPS-1:0] tapGroup [NUM_SLOTS];

  genvar s, j;
  generate
    for (s = 0; s < NUM_SLOTS; s++) begin : g_slot
      for (j = 0; j < TAPS; j++) begin : g_tap
        if (s * STRIDE + j < NUM_TRACKS) begin : g_wire
          assign tapGroup[s][j] = trackVal[s * STRIDE + j];
        end else begin : g_tie
          assign tapGroup[s][j] = 1'b0;
        end
      end
    end
  endgenerate

  logic picked;

  always_comb begin
    picked = 1'b0;
    if (int'(strobe.offset) < TAPS && int'(strobe.slot) < NUM_SLOTS)
      picked = tapGroup[strobe.slot][strobe.offset];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outBit <= 1'b0;
      selErr <= 1'b0;
    end else if (strobe.load) begin
      outBit <= strobe.err ? 1'b0 : picked;
      selErr <= strobe.err;
    end
  end

endmodule

// File: rtl/shift_tolerant_cb_input.sv
module shift_tolerant_cb_input
  import cb_input_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic [NUM_TRACKS-1:0] trackVal,
  input  logic [IDX_W-1:0]      baseTrack,
  input  logic [IDX_W-1:0]      defectTrack,
  input  logic [SHIFT_W-1:0]    shiftAmt,
  output logic                  outValid,
  output logic                  outBit,
  output logic                  selErr
);

  selStrobe_t strobe;

  cb_input_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .baseTrack  (baseTrack),
    .defectTrack(defectTrack),
    .shiftAmt   (shiftAmt),
    .strobe     (strobe),
    .outValid   (outValid)
  );

  cb_input_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .trackVal(trackVal),
    .strobe  (strobe),
    .outBit  (outBit),
    .selErr  (selErr)
  );

endmodule

// File: rtl/cb_input_checker.sv
module cb_input_checker
  import cb_input_pkg::*;
(
  input logic                  clk,
  input logic                  rstN,
  input logic                  reqValid,
  input logic [NUM_TRACKS-1:0] trackVal,
  input logic [IDX_W-1:0]      baseTrack,
  input logic [IDX_W-1:0]      defectTrack,
  input logic [SHIFT_W-1:0]    shiftAmt,
  input logic                  outValid,
  input logic                  outBit,
  input logic                  selErr
);

  // R1: outputs cleared in the cycle after reset
  a_r1_reset_clear: assert property (@(posedge clk)
    !rstN |=> (!outValid && !outBit && !selErr));

  // R2: result valid exactly one cycle after a request
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> outValid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !outValid);

  // R3: below the defect, the base track is read unchanged
  a_r3_unshifted: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !baseTrack[0] && baseTrack < defectTrack && shiftAmt != 2'd3)
      |=> (!selErr && outBit == $past(trackVal[baseTrack])));

  // R5: odd base track is outside the connected set
  a_r5_odd_base: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && baseTrack[0]) |=> selErr);

  // R6: illegal shift code
  a_r6_bad_shift: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && shiftAmt == 2'd3) |=> selErr);

  // R5, R6, R7: an error result never carries a data bit
  a_r7_err_zero: assert property (@(posedge clk) disable iff (!rstN)
    selErr |-> !outBit);

  // R8: results hold while idle
  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!reqValid && rstN) |=> ($stable(outBit) && $stable(selErr)));

endmodule

bind shift_tolerant_cb_input cb_input_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .trackVal   (trackVal),
  .baseTrack  (baseTrack),
  .defectTrack(defectTrack),
  .shiftAmt   (shiftAmt),
  .outValid   (outValid),
  .outBit     (outBit),
  .selErr     (selErr)
);

// File: tb/shift_tolerant_cb_input_test.sv
module shift_tolerant_cb_input_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [15:0] trackVal = '0;
  logic [3:0]  baseTrack = '0;
  logic [3:0]  defectTrack = '0;
  logic [1:0]  shiftAmt = '0;
  logic        outValid, outBit, selErr;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct {
    logic  expBit;
    logic  expErr;
    string tag;
  } item_t;

  item_t sbq[$];
  logic  lastBit = 1'b0;
  logic  lastErr = 1'b0;

  shift_tolerant_cb_input uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .trackVal(trackVal),
    .baseTrack(baseTrack), .defectTrack(defectTrack), .shiftAmt(shiftAmt),
    .outValid(outValid), .outBit(outBit), .selErr(selErr)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string tag, input logic act, input logic exp,
                       input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  // Driver: presents one request and pushes the expected result.
  task automatic drive(input logic [15:0] tv, input int base, input int dfx,
                       input int sh);
    item_t it;
    int    eff;
    @(negedge clk);
    reqValid    = 1'b1;
    trackVal    = tv;
    baseTrack   = 4'(base);
    defectTrack = 4'(dfx);
    shiftAmt    = 2'(sh);
    eff = (base >= dfx) ? base + sh : base;
    if (base % 2 != 0) begin
      it.expErr = 1'b1; it.expBit = 1'b0; it.tag = "R5";
    end else if (sh == 3) begin
      it.expErr = 1'b1; it.expBit = 1'b0; it.tag = "R6";
    end else if (eff > 15) begin
      it.expErr = 1'b1; it.expBit = 1'b0; it.tag = "R7";
    end else begin
      it.expErr = 1'b0; it.expBit = tv[eff];
      it.tag = (base >= dfx) ? "R4" : "R3";
    end
    sbq.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      reqValid = 1'b0;
      trackVal = 16'($urandom);
    end
  endtask

  // Monitor: compares each result against the scoreboard.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rstN && !done) begin
        if (outValid) begin
          item_t it;
          if (sbq.size() == 0) begin
            check("R2", outValid, 1'b0, "outValid with no request");
          end else begin
            it = sbq.pop_front();
            check(it.tag, selErr, it.expErr, "selErr");
            check(it.tag, outBit, it.expBit, "outBit");
          end
          lastBit = outBit;
          lastErr = selErr;
        end else begin
          // R8: held values while idle
          if (sbq.size() != 0)
            check("R2", outValid, 1'b1, "outValid missing");
          check("R8", outBit, lastBit, "outBit hold");
          check("R8", selErr, lastErr, "selErr hold");
        end
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check("R1", outValid, 1'b0, "outValid in reset");
    check("R1", outBit, 1'b0, "outBit in reset");
    check("R1", selErr, 1'b0, "selErr in reset");
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #1;
    check("R1", outValid, 1'b0, "outValid after reset");
    check("R2", outValid, 1'b0, "no request yet");

    // R3 and R4 sweep: every defect, every even base, every legal shift
    for (int d = 0; d < 16; d++)
      for (int b = 0; b < 16; b += 2)
        for (int s = 0; s < 3; s++)
          drive(16'($urandom), b, d, s);
    idle(3);

    // R4 with one-hot channels so a wrong tap cannot match by chance
    for (int s = 0; s < 3; s++) drive(16'(1) << (6 + s), 6, 6, s);
    // R3 boundary: defect one above base, shift ignored
    for (int s = 0; s < 3; s++) drive(16'(1) << 6, 6, 7, s);
    idle(2);

    // R7: top of channel
    drive(16'h8000, 14, 0, 1);
    drive(16'hFFFF, 14, 0, 2);
    drive(16'hFFFF, 14, 15, 2);
    idle(2);

    // R5: odd bases
    for (int b = 1; b < 16; b += 2) drive(16'hFFFF, b, 0, 0);
    idle(2);

    // R6: illegal shift, below and above defect
    drive(16'hFFFF, 4, 0, 3);
    drive(16'hFFFF, 4, 10, 3);
    drive(16'hFFFF, 2, 2, 1);
    idle(4);

    // R2 and R8: a long idle after an error and after a data result
    drive(16'hFFFF, 0, 0, 0);
    idle(5);

    done = 1'b1;
    if (sbq.size() != 0) begin
      fails++;
      $display("FAIL R2 pending results actual=%0d expected=0", sbq.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule